// File: doc/BRIEF.md
# Dual Countdown Timer Unit

This block keeps two 8-bit down-counters, a delay counter and a sound counter, and steps both of them down by one on a shared slow tick of 60 Hz. A prescaler divides the system clock down to make that tick. A processor loads either counter through one write strobe, a select bit and a data byte. It can read the delay counter back at any time on a dedicated output.

When the sound counter runs out on a tick, the block raises a single-cycle beep pulse. A counter that has reached zero stays at zero. A write always takes priority over a decrement in the same cycle. Audio tone generation belongs to other logic.

Top module: `dual_countdown_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `delay_val` is 0 and `beep` is 0. The prescaler also restarts from zero, so the first tick comes exactly CLK_HZ/TICK_HZ cycles after reset is released.
- R2: A single tick enable is asserted for one cycle out of every CLK_HZ/TICK_HZ cycles. On that edge each nonzero counter that is not being written drops by exactly one.
- R3: A counter at zero stays at zero on a tick and never wraps to 255.
- R4: `beep` is high for exactly one cycle, namely the cycle right after the tick edge on which the sound counter moved from 1 to 0.
- R5: When `ld_stb` is high with `ld_sel`=0, `ld_data` is written into the delay counter, and `delay_val` shows it in the next cycle.
- R6: A write and a tick in the same cycle: the written value is stored, with no decrement. A sound write at that moment also suppresses the beep.
- R7: Writing 0 into the sound counter (`ld_sel`=1) never produces a beep. A sound write leaves the delay counter unchanged.
- R8: Writing N>0 into the sound counter gives exactly one beep, which follows the N-th tick after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | Write strobe for the selected counter |
| ld_sel | input | 1 | Counter select: 0 = delay, 1 = sound |
| ld_data | input | 8 | Value to write |
| delay_val | output | 8 | Current delay counter value |
| beep | output | 1 | One-cycle pulse when the sound counter expires |

## Verification
Directed patterns are used first:
- An idle delay count tells an ordinary decrement apart from saturation at zero.
- A write placed exactly on the tick cycle tells load priority apart from decrement priority.
- A sound write of zero, of one on the tick and of a small N tells a genuine expiry apart from a spurious or suppressed beep.

After these, seeded random writes with small values exercise zero crossings often. A cycle-accurate bench model of the prescaler and both counters checks `delay_val` and `beep` in every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic {
    SEL_DELAY = 1'b0,
    SEL_SOUND = 1'b1
  } tmr_sel_e;

  localparam int unsigned TMR_W   = 8;
  localparam int unsigned NUM_TMR = 2;

  // Saturating step-down used on every tick.
  function automatic logic [TMR_W-1:0] dec_sat(input logic [TMR_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  // True when the next tick will bring the counter to zero.
  function automatic logic at_last(input logic [TMR_W-1:0] v);
    return v == TMR_W'(1);
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned CLK_HZ  = 48_000_000,
  parameter int unsigned TICK_HZ = 60
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned DIV = CLK_HZ / TICK_HZ;
  localparam int unsigned CW  = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap_evt;

  assign wrap_evt = (cnt_q == CW'(DIV - 1));
  assign tick     = wrap_evt;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (wrap_evt) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R2: tick is a single-cycle enable
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R2: counter never exceeds the division limit
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DIV - 1));

endmodule

// File: rtl/countdown_reg.sv
module countdown_reg
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld,
  input  logic [TMR_W-1:0] ld_data,
  output logic [TMR_W-1:0] value
);
  logic [TMR_W-1:0] val_q;
  logic             step_evt;

  assign step_evt = tick && !ld;
  assign value    = val_q;

  always_ff @(posedge clk) begin
    if (rst)           val_q <= '0;
    else if (ld)       val_q <= ld_data;
    else if (step_evt) val_q <= dec_sat(val_q);
  end

  // R6: a write always lands, tick or not
  p_load_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ld |=> value == $past(ld_data));

  // R3: zero holds when not written
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld && value == '0) |=> value == '0);

  // R2: one step down per tick
  p_dec_one_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && value != '0) |=> value == $past(value) - 1'b1);

  // R2: no change between ticks
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(value));

endmodule

// File: rtl/beep_gen.sv
module beep_gen
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             snd_ld,
  input  logic [TMR_W-1:0] snd_val,
  output logic             beep
);
  logic expire_evt;
  logic beep_q;

  assign expire_evt = tick && !snd_ld && at_last(snd_val);
  assign beep       = beep_q;

  always_ff @(posedge clk) begin
    if (rst) beep_q <= 1'b0;
    else     beep_q <= expire_evt;
  end

  // R4: pulse lasts one cycle
  p_beep_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    beep |=> !beep);

  // R4: beep follows a 1 -> 0 step of the sound counter
  p_beep_cause_r4: assert property (@(posedge clk) disable iff (rst)
    beep |-> (snd_val == '0 && $past(snd_val) == TMR_W'(1)));

  // R7: a sound write never causes a beep
  p_ld_silent_r7: assert property (@(posedge clk) disable iff (rst)
    snd_ld |=> !beep);

endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 48_000_000,
  parameter int unsigned TICK_HZ = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld_stb,
  input  logic       ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] delay_val,
  output logic       beep
);
  logic                        tick_w;
  logic [NUM_TMR-1:0]          ld_w;
  logic [NUM_TMR-1:0][TMR_W-1:0] val_w;

  tick_prescaler #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick_w)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    assign ld_w[g] = ld_stb && (ld_sel == g[0]);
    countdown_reg u_cd (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick_w),
      .ld     (ld_w[g]),
      .ld_data(ld_data),
      .value  (val_w[g])
    );
  end

  beep_gen u_bp (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_w),
    .snd_ld (ld_w[SEL_SOUND]),
    .snd_val(val_w[SEL_SOUND]),
    .beep   (beep)
  );

  assign delay_val = val_w[SEL_DELAY];

  // R5/R7: only one counter is written per strobe
  p_one_load_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_w));

  // R7: a sound write leaves the delay counter alone
  p_delay_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (ld_w[SEL_SOUND] && !tick_w) |=> $stable(delay_val));

endmodule

// File: tb/sim_dual_countdown_timer.sv
`timescale 1ns/1ps
module sim_dual_countdown_timer;
  localparam int unsigned CLK_HZ = 600;
  localparam int unsigned DIV    = CLK_HZ / 60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_stb = 1'b0;
  logic       ld_sel = 1'b0;
  logic [7:0] ld_data = 8'd0;
  logic [7:0] delay_val;
  logic       beep;

  int n_chk  = 0;
  int n_fail = 0;
  int n_beep = 0;

  // bench model state
  int       m_cnt = 0;
  bit [7:0] m_dly = 0;
  bit [7:0] m_snd = 0;
  bit       m_bp  = 0;

  always #2 clk = ~clk;

  dual_countdown_timer #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_sel(ld_sel),
    .ld_data(ld_data), .delay_val(delay_val), .beep(beep)
  );

  function automatic bit [7:0] model_step(bit [7:0] v, bit t, bit ld, bit [7:0] d);
    if (ld) return d;
    if (t && v != 0) return v - 8'd1;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive inputs at negedge, advance model, check at next negedge
  task automatic step(string tag, bit ld, bit sel, bit [7:0] d);
    bit t;
    ld_stb = ld; ld_sel = sel; ld_data = d;
    t = (m_cnt == DIV - 1);
    m_bp  = t && m_snd == 8'd1 && !(ld && sel);
    m_dly = model_step(m_dly, t, ld && !sel, d);
    m_snd = model_step(m_snd, t, ld && sel, d);
    m_cnt = t ? 0 : m_cnt + 1;
    @(posedge clk);
    @(negedge clk);
    ld_stb = 1'b0;
    if (beep) n_beep++;
    chk({tag, " delay"}, delay_val, m_dly);
    chk({tag, " beep"},  beep, m_bp);
  endtask

  task automatic align_to_tick();
    while (m_cnt != DIV - 1) step("R2 align", 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 reset delay", delay_val, 0);
    chk("R1 reset beep", beep, 0);
    rst = 1'b0;
    m_cnt = 0; m_dly = 0; m_snd = 0; m_bp = 0;

    // R1/R3: idle, zero counters stay at zero across several ticks
    for (int k = 0; k < 3 * DIV; k++) step("R3 idle", 0, 0, 0);
    chk("R3 delay still zero", delay_val, 0);

    // R5: write delay and read back
    step("R5 load delay", 1, 0, 8'd5);
    chk("R5 readback", delay_val, 5);
    // R2: count down to zero and beyond
    for (int k = 0; k < 7 * DIV; k++) step("R2 countdown", 0, 0, 0);
    chk("R3 saturated", delay_val, 0);

    // R6: delay write lands on the tick cycle
    align_to_tick();
    step("R6 load on tick", 1, 0, 8'd9);
    chk("R6 load wins", delay_val, 9);

    // R8: sound write of 3 gives one beep after 3 ticks
    n_beep = 0;
    step("R8 load sound", 1, 1, 8'd3);
    for (int k = 0; k < 5 * DIV; k++) step("R8 sound run", 0, 0, 0);
    chk("R8 beep count", n_beep, 1);

    // R7: sound write of zero never beeps
    n_beep = 0;
    step("R7 load zero", 1, 1, 8'd0);
    for (int k = 0; k < 3 * DIV; k++) step("R7 zero run", 0, 0, 0);
    chk("R7 beep count", n_beep, 0);

    // R6: sound at 1, rewrite on the tick suppresses the beep
    n_beep = 0;
    step("R6 load sound one", 1, 1, 8'd1);
    align_to_tick();
    step("R6 reload on tick", 1, 1, 8'd0);
    for (int k = 0; k < 2 * DIV; k++) step("R6 after reload", 0, 0, 0);
    chk("R6 beep suppressed", n_beep, 0);

    // R4: sound at 1, expiry on a plain tick
    n_beep = 0;
    step("R4 load sound one", 1, 1, 8'd1);
    for (int k = 0; k < 2 * DIV; k++) step("R4 expire", 0, 0, 0);
    chk("R4 single beep", n_beep, 1);

    // random mix of writes with small values
    for (int k = 0; k < 4000; k++) begin
      bit       ld  = ($urandom % 12) == 0;
      bit       sel = $urandom % 2;
      bit [7:0] d   = 8'($urandom % 4);
      step("R2 random", ld, sel, d);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule